// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

This block walks the register list of a block load or block store, issuing one register number per memory transfer, lowest number first. A transfer is offered on `xfer_o` with the register on `reg_num_o` and is accepted in the cycle where `mem_rdy_i` is high. When an interrupt request arrives, the sequence can stop at a transfer boundary. The number of the next outstanding register is parked in a 32-bit execution-state word. When the interrupt return arrives, the sequence picks up at exactly that register instead of replaying the list.

The execution-state word also holds the execution-mode bit at position 24. Interrupt return, exception entry and register-branch updates load this bit from their own input. Starting or resuming while it is clear is refused with a fault pulse. Software-style access to the word is modelled as well: reads return zero and writes are discarded.

Top module: `mreg_seq`

## Requirements
- R1: After reset the state word reads 0x00000000, and `xfer_o`, `done_o` and `fault_o` are low.
- R2: Registers whose list bit is set are offered in ascending order, one per accepted transfer (a cycle with `xfer_o` and `mem_rdy_i` both high). Registers whose list bit is clear are skipped.
- R3: A start with an all-zero list raises `done_o` for one cycle on the next cycle and offers no transfer.
- R4: `done_o` pulses for one cycle in the cycle after the last register is accepted, and `xfer_o` is then low.
- R5: An interrupt request that is high when a transfer is accepted, with list bits still remaining, stops the sequence. `xfer_o` goes low and bits [15:12] of the state word hold the next register number.
- R6: An interrupt request is not taken while a transfer waits for ready. `xfer_o` stays high and `reg_num_o` stays stable.
- R7: An interrupt request on the last transfer of the list is not taken. The sequence completes with `done_o`, and bits [15:12] stay zero.
- R8: State-word bits [26:25] and [11:10] are always zero. Bits [15:12] are zero except while the sequence is suspended.
- R9: An interrupt return loads bit 24 from `ret_tbit_i`. If that bit is 1, transfers resume at the register held in bits [15:12]; the field clears as that transfer is offered, and the rest of the list completes.
- R10: `sw_rdata_o` always reads zero, and a software write (`sw_wr_i`) leaves the state word unchanged.
- R11: Each of the following loads bit 24 from its own data input: an interrupt return, an exception entry (`exc_i`, from bit 0 of the vector) and a branch update (`br_i`). The priority is return over entry over branch.
- R12: A start, or a resume, with bit 24 equal to 0 pulses `fault_o` on the next cycle and offers no transfer. A faulting resume returns to idle with bits [15:12] cleared.
- R13: A start pulse while a transfer is active or suspended is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_list_i | input | 16 | Register list, bit n selects register n |
| start_i | input | 1 | Start pulse |
| irq_i | input | 1 | Interrupt request |
| irq_ret_i | input | 1 | Interrupt return pulse |
| ret_tbit_i | input | 1 | Mode bit restored on interrupt return |
| mem_rdy_i | input | 1 | Memory ready, accepts the offered transfer |
| exc_i | input | 1 | Exception entry pulse |
| exc_tbit_i | input | 1 | Bit 0 of the vector value |
| br_i | input | 1 | Register-branch update pulse |
| br_tbit_i | input | 1 | Bit 0 of the branch target |
| sw_rd_i | input | 1 | Software read strobe |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 32 | Software write data |
| reg_num_o | output | 4 | Register number of the offered transfer |
| xfer_o | output | 1 | Transfer offered |
| done_o | output | 1 | List complete pulse |
| fault_o | output | 1 | Mode-bit fault pulse |
| xstate_o | output | 32 | Execution-state word |
| sw_rdata_o | output | 32 | Software read data |

## Verification
On every cycle the assertions check four things: that the reserved fields of the state word stay zero, that the resume field is empty outside suspension, that a stalled transfer holds its register, and that start, empty-list and resume responses arrive one cycle after the request. Only the bench scenarios can show that the full register order matches the expected ascending order across random lists, random stalls and random interrupt points. The same applies to the end of a run: that a suspended sequence finishes exactly the outstanding registers, and that software writes and stray starts leave no trace.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  localparam int LIST_W   = 16;
  localparam int IDX_W    = $clog2(LIST_W);
  localparam int WORD_W   = 32;
  localparam int TBIT_POS = 24;
  localparam int IDX_LSB  = 12;
  // Application-level access rights to the state word; both fixed off.
  localparam bit SW_RD_OK = 1'b0;
  localparam bit SW_WR_OK = 1'b0;
  localparam logic [WORD_W-1:0] LIVE_MASK =
    (WORD_W'(1) << TBIT_POS) | (WORD_W'((1 << IDX_W) - 1) << IDX_LSB);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_SUSP = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mreg_rst_sync.sv
module mreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/mreg_lowbit.sv
module mreg_lowbit #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [W:0]   seen;
  logic [W-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < W; g++) begin : g_chain
    assign seen[g+1] = seen[g] | vec_i[g];
    assign first[g]  = vec_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx_o = idx_o | IW'(i);
    end
  end

  assign any_o = seen[W];
endmodule

// File: rtl/mreg_xstate.sv
module mreg_xstate
  import mreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_i,
  input  logic              ret_tbit_i,
  input  logic              exc_i,
  input  logic              exc_tbit_i,
  input  logic              br_i,
  input  logic              br_tbit_i,
  input  logic              idx_ld_i,
  input  logic [IDX_W-1:0]  idx_val_i,
  input  logic              idx_clr_i,
  input  logic              sw_rd_i,
  input  logic              sw_wr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic              tbit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] sw_rdata_o
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_raw;
  logic              word_en;

  always_comb begin
    word_raw = word_q;
    if (SW_WR_OK && sw_wr_i) word_raw = sw_wdata_i;
    if (ret_i)        word_raw[TBIT_POS] = ret_tbit_i;
    else if (exc_i)   word_raw[TBIT_POS] = exc_tbit_i;
    else if (br_i)    word_raw[TBIT_POS] = br_tbit_i;
    if (idx_clr_i)     word_raw[IDX_LSB +: IDX_W] = '0;
    else if (idx_ld_i) word_raw[IDX_LSB +: IDX_W] = idx_val_i;
    word_d  = word_raw & LIVE_MASK;
    word_en = ret_i | exc_i | br_i | idx_clr_i | idx_ld_i | (SW_WR_OK & sw_wr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign tbit_o     = word_q[TBIT_POS];
  assign idx_o      = word_q[IDX_LSB +: IDX_W];
  assign word_o     = word_q;
  assign sw_rdata_o = (SW_RD_OK && sw_rd_i) ? word_q : '0;
endmodule

// File: rtl/mreg_ctrl.sv
module mreg_ctrl
  import mreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LIST_W-1:0] list_i,
  input  logic              irq_i,
  input  logic              ret_i,
  input  logic              ret_tbit_i,
  input  logic              rdy_i,
  input  logic              tbit_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              xfer_o,
  output logic [IDX_W-1:0]  reg_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              idx_ld_o,
  output logic [IDX_W-1:0]  idx_val_o,
  output logic              idx_clr_o,
  output logic              idle_o,
  output logic              susp_o
);
  seq_st_e           st_q, st_d;
  logic [LIST_W-1:0] rem_q, rem_d, rem_after;
  logic [IDX_W-1:0]  cur_q, cur_d;
  logic              done_q, done_d, fault_q, fault_d;
  logic              seq_en;
  logic [IDX_W-1:0]  start_idx, after_idx;
  logic              start_any, after_any;

  assign rem_after = rem_q & ~(LIST_W'(1) << cur_q);

  mreg_lowbit #(.W(LIST_W), .IW(IDX_W)) u_first (
    .vec_i (list_i),
    .idx_o (start_idx),
    .any_o (start_any)
  );

  mreg_lowbit #(.W(LIST_W), .IW(IDX_W)) u_next (
    .vec_i (rem_after),
    .idx_o (after_idx),
    .any_o (after_any)
  );

  always_comb begin
    st_d      = st_q;
    rem_d     = rem_q;
    cur_d     = cur_q;
    done_d    = 1'b0;
    fault_d   = 1'b0;
    idx_ld_o  = 1'b0;
    idx_clr_o = 1'b0;
    idx_val_o = after_idx;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!tbit_i) begin
            fault_d = 1'b1;
          end else if (!start_any) begin
            done_d = 1'b1;
          end else begin
            st_d  = ST_XFER;
            rem_d = list_i;
            cur_d = start_idx;
          end
        end
      end
      ST_XFER: begin
        if (rdy_i) begin
          rem_d = rem_after;
          if (!after_any) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else if (irq_i) begin
            st_d     = ST_SUSP;
            idx_ld_o = 1'b1;
          end else begin
            cur_d = after_idx;
          end
        end
      end
      ST_SUSP: begin
        if (ret_i) begin
          idx_clr_o = 1'b1;
          if (!ret_tbit_i) begin
            fault_d = 1'b1;
            st_d    = ST_IDLE;
            rem_d   = '0;
          end else begin
            st_d  = ST_XFER;
            cur_d = idx_i;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    seq_en = (st_d != st_q) | (rem_d != rem_q) | (cur_d != cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      cur_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      rem_q <= rem_d;
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign xfer_o  = (st_q == ST_XFER);
  assign reg_o   = cur_q;
  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign idle_o  = (st_q == ST_IDLE);
  assign susp_o  = (st_q == ST_SUSP);
endmodule

// File: rtl/mreg_seq.sv
module mreg_seq
  import mreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIST_W-1:0] reg_list_i,
  input  logic              start_i,
  input  logic              irq_i,
  input  logic              irq_ret_i,
  input  logic              ret_tbit_i,
  input  logic              mem_rdy_i,
  input  logic              exc_i,
  input  logic              exc_tbit_i,
  input  logic              br_i,
  input  logic              br_tbit_i,
  input  logic              sw_rd_i,
  input  logic              sw_wr_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [IDX_W-1:0]  reg_num_o,
  output logic              xfer_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [WORD_W-1:0] xstate_o,
  output logic [WORD_W-1:0] sw_rdata_o
);
  logic             rst_sync_n;
  logic             tbit;
  logic [IDX_W-1:0] idx;
  logic             idx_ld, idx_clr;
  logic [IDX_W-1:0] idx_val;
  logic             ctl_idle, ctl_susp;

  mreg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mreg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .list_i     (reg_list_i),
    .irq_i      (irq_i),
    .ret_i      (irq_ret_i),
    .ret_tbit_i (ret_tbit_i),
    .rdy_i      (mem_rdy_i),
    .tbit_i     (tbit),
    .idx_i      (idx),
    .xfer_o     (xfer_o),
    .reg_o      (reg_num_o),
    .done_o     (done_o),
    .fault_o    (fault_o),
    .idx_ld_o   (idx_ld),
    .idx_val_o  (idx_val),
    .idx_clr_o  (idx_clr),
    .idle_o     (ctl_idle),
    .susp_o     (ctl_susp)
  );

  mreg_xstate u_xstate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ret_i      (irq_ret_i),
    .ret_tbit_i (ret_tbit_i),
    .exc_i      (exc_i),
    .exc_tbit_i (exc_tbit_i),
    .br_i       (br_i),
    .br_tbit_i  (br_tbit_i),
    .idx_ld_i   (idx_ld),
    .idx_val_i  (idx_val),
    .idx_clr_i  (idx_clr),
    .sw_rd_i    (sw_rd_i),
    .sw_wr_i    (sw_wr_i),
    .sw_wdata_i (sw_wdata_i),
    .tbit_o     (tbit),
    .idx_o      (idx),
    .word_o     (xstate_o),
    .sw_rdata_o (sw_rdata_o)
  );
endmodule

// File: rtl/mreg_seq_chk.sv
module mreg_seq_chk
  import mreg_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              start_i,
  input logic [LIST_W-1:0] reg_list_i,
  input logic              irq_ret_i,
  input logic              ret_tbit_i,
  input logic              mem_rdy_i,
  input logic              xfer_o,
  input logic [IDX_W-1:0]  reg_num_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [WORD_W-1:0] xstate_o,
  input logic              idle,
  input logic              susp
);
  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_sn)
    (xstate_o[26:25] == 2'b00) && (xstate_o[11:10] == 2'b00)); // R8

  AST_IDX_ONLY_SUSP: assert property (@(posedge clk) disable iff (!rst_sn)
    !susp |-> (xstate_o[IDX_LSB +: IDX_W] == '0)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (xfer_o && !mem_rdy_i) |=> (xfer_o && $stable(reg_num_o))); // R6

  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle && start_i && xstate_o[TBIT_POS] && (reg_list_i == '0)) |=> (done_o && !xfer_o)); // R3

  AST_START_FAULT: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle && start_i && !xstate_o[TBIT_POS]) |=> (fault_o && !xfer_o)); // R12

  AST_RESUME_REG: assert property (@(posedge clk) disable iff (!rst_sn)
    (susp && irq_ret_i && ret_tbit_i) |=> (xfer_o && (reg_num_o == $past(xstate_o[IDX_LSB +: IDX_W])))); // R9

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (susp && !irq_ret_i) |=> (susp && !xfer_o)); // R13

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({done_o, fault_o})); // R4
endmodule

bind mreg_seq mreg_seq_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sync_n),
  .start_i    (start_i),
  .reg_list_i (reg_list_i),
  .irq_ret_i  (irq_ret_i),
  .ret_tbit_i (ret_tbit_i),
  .mem_rdy_i  (mem_rdy_i),
  .xfer_o     (xfer_o),
  .reg_num_o  (reg_num_o),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .xstate_o   (xstate_o),
  .idle       (ctl_idle),
  .susp       (ctl_susp)
);

// File: tb/mreg_seq_bench.sv
module mreg_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_list_i;
  logic        start_i, irq_i, irq_ret_i, ret_tbit_i, mem_rdy_i;
  logic        exc_i, exc_tbit_i, br_i, br_tbit_i;
  logic        sw_rd_i, sw_wr_i;
  logic [31:0] sw_wdata_i;
  logic [3:0]  reg_num_o;
  logic        xfer_o, done_o, fault_o;
  logic [31:0] xstate_o, sw_rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit running = 1'b0;

  mreg_seq u_mreg_seq (
    .clk(clk), .rst_n(rst_n), .reg_list_i(reg_list_i), .start_i(start_i),
    .irq_i(irq_i), .irq_ret_i(irq_ret_i), .ret_tbit_i(ret_tbit_i),
    .mem_rdy_i(mem_rdy_i), .exc_i(exc_i), .exc_tbit_i(exc_tbit_i),
    .br_i(br_i), .br_tbit_i(br_tbit_i), .sw_rd_i(sw_rd_i), .sw_wr_i(sw_wr_i),
    .sw_wdata_i(sw_wdata_i), .reg_num_o(reg_num_o), .xfer_o(xfer_o),
    .done_o(done_o), .fault_o(fault_o), .xstate_o(xstate_o),
    .sw_rdata_o(sw_rdata_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R8, R10 on every cycle once running
  always @(negedge clk) begin
    if (running) begin
      chk(xstate_o[26:25] == 2'b00 && xstate_o[11:10] == 2'b00, "R8 zero fields", xstate_o, xstate_o & ~32'h0600_0C00);
      chk(sw_rdata_o == 32'h0, "R10 read zero", sw_rdata_o, 32'h0);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_seq(input logic [15:0] lst, input int irq_at, input bit stall, input bit ret_ok);
    int exp_r[16];
    int n = 0;
    int k = 0;
    bit first = 1'b1;
    for (int i = 0; i < 16; i++) if (lst[i]) begin exp_r[n] = i; n++; end
    reg_list_i = lst; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    if (n == 0) begin
      chk(done_o == 1'b1, "R3 empty done", 32'(done_o), 32'h1);
      chk(xfer_o == 1'b0, "R3 empty no xfer", 32'(xfer_o), 32'h0);
      tick();
      return;
    end
    while (k < n) begin
      bit rdy;
      chk(xfer_o == 1'b1, "R2 xfer offered", 32'(xfer_o), 32'h1);
      chk(reg_num_o == 4'(exp_r[k]), "R2 order", 32'(reg_num_o), 32'(exp_r[k]));
      rdy = stall ? 1'($urandom_range(0, 1)) : 1'b1;
      mem_rdy_i = rdy;
      irq_i = (k == irq_at);
      // R13: stray start while active
      start_i = first; reg_list_i = 16'hFFFF; first = 1'b0;
      tick();
      start_i = 1'b0; mem_rdy_i = 1'b0;
      if (!rdy) begin
        chk(xfer_o == 1'b1, "R6 irq not taken in stall", 32'(xfer_o), 32'h1);
        continue;
      end
      k++;
      irq_i = 1'b0;
      if (k - 1 == irq_at && k < n) begin
        logic [31:0] saved;
        chk(xfer_o == 1'b0, "R5 suspended", 32'(xfer_o), 32'h0);
        chk(xstate_o[15:12] == 4'(exp_r[k]), "R5 resume index", 32'(xstate_o[15:12]), 32'(exp_r[k]));
        saved = xstate_o;
        start_i = 1'b1; reg_list_i = 16'h0001;
        tick();
        start_i = 1'b0;
        tick();
        chk(xstate_o == saved, "R13 start ignored in suspend", xstate_o, saved);
        chk(xfer_o == 1'b0, "R13 no xfer in suspend", 32'(xfer_o), 32'h0);
        irq_ret_i = 1'b1; ret_tbit_i = ret_ok;
        tick();
        irq_ret_i = 1'b0;
        if (!ret_ok) begin
          chk(fault_o == 1'b1, "R12 resume fault", 32'(fault_o), 32'h1);
          chk(xfer_o == 1'b0, "R12 no xfer", 32'(xfer_o), 32'h0);
          chk(xstate_o == 32'h0, "R12 word cleared", xstate_o, 32'h0);
          tick();
          return;
        end
        chk(xstate_o == 32'h0100_0000, "R9 index cleared, mode set", xstate_o, 32'h0100_0000);
      end
    end
    chk(done_o == 1'b1, "R4 done pulse", 32'(done_o), 32'h1);
    chk(xfer_o == 1'b0, "R4 idle after done", 32'(xfer_o), 32'h0);
    chk(xstate_o[15:12] == 4'h0, "R7 no index after completion", 32'(xstate_o[15:12]), 32'h0);
    tick();
    chk(done_o == 1'b0, "R4 done one cycle", 32'(done_o), 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_list_i = '0; start_i = 0; irq_i = 0; irq_ret_i = 0;
    ret_tbit_i = 0; mem_rdy_i = 0; exc_i = 0; exc_tbit_i = 0; br_i = 0;
    br_tbit_i = 0; sw_rd_i = 0; sw_wr_i = 0; sw_wdata_i = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    running = 1'b1;
    chk(xstate_o == 32'h0, "R1 reset word", xstate_o, 32'h0);
    chk({xfer_o, done_o, fault_o} == 3'b000, "R1 reset outputs", 32'({xfer_o, done_o, fault_o}), 32'h0);

    // R12: start with mode bit clear
    reg_list_i = 16'h0003; start_i = 1'b1; tick(); start_i = 1'b0;
    chk(fault_o == 1'b1, "R12 start fault", 32'(fault_o), 32'h1);
    chk(xfer_o == 1'b0, "R12 start no xfer", 32'(xfer_o), 32'h0);
    tick();

    // R11: exception entry, priority over branch
    exc_i = 1; exc_tbit_i = 1; tick(); exc_i = 0;
    chk(xstate_o == 32'h0100_0000, "R11 vector bit loads mode", xstate_o, 32'h0100_0000);
    exc_i = 1; exc_tbit_i = 0; br_i = 1; br_tbit_i = 1; tick(); exc_i = 0; br_i = 0;
    chk(xstate_o == 32'h0, "R11 entry beats branch", xstate_o, 32'h0);
    irq_ret_i = 1; ret_tbit_i = 1; exc_i = 1; exc_tbit_i = 0; tick(); irq_ret_i = 0; exc_i = 0;
    chk(xstate_o == 32'h0100_0000, "R11 return beats entry", xstate_o, 32'h0100_0000);

    // R10: software write ignored
    sw_wr_i = 1; sw_wdata_i = 32'hFFFF_FFFF; sw_rd_i = 1; tick(); sw_wr_i = 0; sw_rd_i = 0;
    chk(xstate_o == 32'h0100_0000, "R10 write ignored", xstate_o, 32'h0100_0000);

    run_seq(16'h0000, -1, 0, 1);                        // R3
    for (int b = 0; b < 16; b++) run_seq(16'(1 << b), 0, 0, 1); // R7 single registers
    run_seq(16'hFFFF, 7, 1, 1);                         // R5 R9
    run_seq(16'h8001, 1, 0, 1);                         // R7 irq on last
    for (int t = 0; t < 400; t++) begin
      logic [15:0] l;
      int cnt;
      l = 16'($urandom);
      cnt = $countones(l);
      run_seq(l, (cnt == 0) ? -1 : int'($urandom_range(0, cnt)) - 1 + (t % 2), t[0] ^ t[2], 1);
    end
    run_seq(16'h00F0, 0, 0, 0);                         // R12 resume fault
    br_i = 1; br_tbit_i = 1; tick(); br_i = 0;
    chk(xstate_o == 32'h0100_0000, "R11 branch loads mode", xstate_o, 32'h0100_0000);
    run_seq(16'h0505, 1, 1, 1);                         // R2 after recovery

    running = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule